// File: doc/BRIEF.md
# Stage-2 Descriptor Table Walker

This block turns an intermediate address into a physical address. It walks a chain of 64-bit translation descriptors held in memory, through at most four levels. A walk starts when a request is accepted on a valid/ready port. The request carries the address and a read/write flag. The configuration pins are sampled in the same cycle and held for the whole walk: address-range size field, granule code, start-level code, root table base, output-size limit and an access-flag fault disable.

The walker issues descriptor reads one at a time on a valid/ready read port. The memory answers each read with a response strobe, the 64-bit data and an error flag. The walk ends with one of two results on a valid/ready response port:

- a leaf translation: output frame address, block mask, aligned input base, access permissions, final level and granule;
- a fault record: fault code, stage and faulting address.

Back-pressure works as follows. A request is accepted only while the walker is idle. A presented read holds its address until the memory accepts it. The response port holds every field steady while `resp_ready` is low, and no new request is taken until the response has been accepted.

Top module: `s2_walker`

## Requirements
- R1: `req_ready` is high only when no walk or response is pending. While `resp_valid` is high and `resp_ready` is low, every response field stays unchanged. A request presented during that time is not taken and causes no memory read.
- R2: If the input address is at or above 2^(64 - tsz), the walk ends with a translation fault (code 1) that records the input address. No memory read is made.
- R3: Granule code 0 (and 3) selects 4 KB, code 1 selects 16 KB and code 2 selects 64 KB. For 4 KB the start level is 2 minus the start code, and start code 3 gives a translation fault with no read. For the other granules the start level is 3 minus the start code.
- R4: The root table is chosen by the address bits above the start level's index field. The root base is the configured base plus that table number times 2^stride times 8 bytes.
- R5: Each descriptor is read from base + index*8. Only one read is outstanding at a time. A read held without acceptance keeps its address. With a read accepted at once and answered in the next cycle, the response is valid 2 + 2*reads cycles after the request is accepted.
- R6: A read that returns with the error flag set ends the walk with an external-abort fault (code 2). The recorded address is the descriptor address.
- R7: A descriptor with bit 0 clear, or with bits 1:0 = 01 at level 3, ends the walk with a translation fault (code 1) that records the input address.
- R8: Bits 1:0 = 11 below level 3 mark a table: its address bits above the granule size become the next base, and the walk moves one level down. Bits 1:0 = 01 below level 3 (block) and bits 1:0 = 11 at level 3 (page) end the walk.
- R9: On success the output address keeps only the descriptor address bits at or above the level shift (granule + (granule-3)*(3-level)). The mask is 2^shift - 1. The input base is the input address with the mask bits cleared.
- R10: When descriptor bit 10 is clear and the fault-disable input is low, the result is an access-flag fault (code 3). This check takes priority over the permission and size checks.
- R11: Descriptor bit 6 grants read and bit 7 grants write. A request whose kind is not granted gets a permission fault (code 4). A permission fault takes priority over a size fault. A successful result returns bits 7:6 as the permission.
- R12: If the output address is at or above 2^(output size), the result is an address-size fault (code 5) that records the input address.
- R13: Fault codes are 0 none, 1 translation, 2 external abort, 3 access flag, 4 permission, 5 address size. On any fault the permission is 0 and the stage is 2. On success the stage is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request taken |
| req_addr | input | AW | Intermediate address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_tsz | input | 6 | Input range size field (range is 2^(64-tsz)) |
| cfg_granule | input | 2 | Granule code |
| cfg_start_code | input | 2 | Start-level code |
| cfg_root_base | input | AW | Root table base address |
| cfg_out_size | input | 6 | Output address size in bits |
| cfg_af_fault_off | input | 1 | Suppress access-flag faults |
| mrd_valid | output | 1 | Descriptor read request valid |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | AW | Descriptor byte address |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_data | input | 64 | Descriptor data |
| mrsp_err | input | 1 | Read ended with a bus error |
| resp_valid | output | 1 | Walk result valid |
| resp_ready | input | 1 | Result accepted |
| resp_fault | output | 3 | Fault code |
| resp_stage | output | 2 | Fault stage (2 on fault) |
| resp_fault_addr | output | AW | Faulting address |
| resp_in_base | output | AW | Input address aligned to the mask |
| resp_mask | output | AW | Block or page offset mask |
| resp_pa | output | AW | Output frame address |
| resp_perm | output | 2 | Permission bits (bit 0 read, bit 1 write) |
| resp_level | output | 2 | Level of the final descriptor |
| resp_granule | output | 2 | Granule code of the walk |

## Verification
A request is taken at a clock edge. The next cycle checks the range and the start level. A fault found there shows on the response port two cycles after acceptance. Otherwise the first read is presented two cycles after acceptance, and each read adds two cycles: one to hand off the read and one to take its data. The bench's memory accepts at once and answers one cycle later. The bench samples on falling edges and counts the falling edges from acceptance to `resp_valid`. It requires exactly 2 + 2*reads for every walk. The back-pressure case holds the response for several cycles and checks, cycle by cycle, that the outputs do not change and no read is made.

// File: rtl/s2w_pkg.sv
package s2w_pkg;

  localparam int unsigned DESC_W = 64;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_XLATE  = 3'd1,
    FLT_EXTABT = 3'd2,
    FLT_ACCESS = 3'd3,
    FLT_PERM   = 3'd4,
    FLT_ASIZE  = 3'd5
  } s2w_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } s2w_state_e;

  typedef enum logic [1:0] {
    DK_INVALID,
    DK_TABLE,
    DK_LEAF
  } s2w_kind_e;

  // log2 of the granule size in bytes
  function automatic logic [4:0] gran_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd14;
      2'd2:    return 5'd16;
      default: return 5'd12;
    endcase
  endfunction

  // address bit at which a descriptor of this level maps its region
  function automatic logic [5:0] lvl_shift(input logic [4:0] g, input logic [1:0] lvl);
    logic [11:0] prod;
    prod = ({7'd0, g} - 12'd3) * ({10'd0, 2'd3 - lvl});
    return 6'({1'b0, g} + prod[5:0]);
  endfunction

endpackage

// File: rtl/s2w_level_geom.sv
module s2w_level_geom
  import s2w_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic [1:0]    gran_code,
  input  logic [1:0]    level,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] lvl_mask,
  output logic [AW-1:0] page_mask,
  output logic [AW-1:0] idx_bytes,
  output logic [AW-1:0] root_bytes
);
  logic [4:0]    g;
  logic [4:0]    stride;
  logic [5:0]    shift;
  logic [AW-1:0] shifted;
  logic [AW-1:0] idx_field;
  logic [AW-1:0] table_no;

  always_comb begin
    g          = gran_bits(gran_code);
    stride     = g - 5'd3;
    shift      = lvl_shift(g, level);
    lvl_mask   = ~({AW{1'b1}} << shift);
    page_mask  = ~({AW{1'b1}} << g);
    shifted    = addr >> shift;
    idx_field  = shifted & ~({AW{1'b1}} << stride);
    idx_bytes  = idx_field << 3;
    // concatenated root tables: table number sits above the index field
    table_no   = shifted >> stride;
    root_bytes = table_no << (stride + 5'd3);
  end
endmodule

// File: rtl/s2w_desc_eval.sv
module s2w_desc_eval
  import s2w_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        level,
  input  logic [AW-1:0]     lvl_mask,
  input  logic [AW-1:0]     page_mask,
  input  logic              req_write,
  input  logic              af_off,
  input  logic [5:0]        out_size,
  output s2w_kind_e         kind,
  output logic [AW-1:0]     next_base,
  output logic [AW-1:0]     leaf_pa,
  output s2w_fault_e        leaf_fault,
  output logic [1:0]        perm
);
  logic [AW-1:0] addr_field;
  logic          last_lvl;
  logic          af_ok;
  logic          perm_ok;
  logic          too_big;

  generate
    if (AW < DESC_W) begin : g_hi_bits
      logic unused_hi_bits;
      assign unused_hi_bits = ^desc[DESC_W-1:AW];
    end
  endgenerate

  always_comb begin
    addr_field = desc[AW-1:0];
    last_lvl   = (level == 2'd3);
    if (!desc[0])
      kind = DK_INVALID;
    else if (desc[1])
      kind = last_lvl ? DK_LEAF : DK_TABLE;
    else
      kind = last_lvl ? DK_INVALID : DK_LEAF;

    next_base = addr_field & ~page_mask;
    leaf_pa   = addr_field & ~lvl_mask;
    perm      = desc[7:6];
    af_ok     = desc[10] | af_off;
    perm_ok   = req_write ? desc[7] : desc[6];
    if (32'(out_size) >= AW)
      too_big = 1'b0;
    else
      too_big = |(leaf_pa >> out_size);

    if (!af_ok)
      leaf_fault = FLT_ACCESS;
    else if (!perm_ok)
      leaf_fault = FLT_PERM;
    else if (too_big)
      leaf_fault = FLT_ASIZE;
    else
      leaf_fault = FLT_NONE;
  end
endmodule

// File: rtl/s2_walker.sv
module s2_walker
  import s2w_pkg::*;
#(
  parameter int unsigned AW = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [5:0]        cfg_tsz,
  input  logic [1:0]        cfg_granule,
  input  logic [1:0]        cfg_start_code,
  input  logic [AW-1:0]     cfg_root_base,
  input  logic [5:0]        cfg_out_size,
  input  logic              cfg_af_fault_off,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [AW-1:0]     mrd_addr,
  input  logic              mrsp_valid,
  input  logic [DESC_W-1:0] mrsp_data,
  input  logic              mrsp_err,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [2:0]        resp_fault,
  output logic [1:0]        resp_stage,
  output logic [AW-1:0]     resp_fault_addr,
  output logic [AW-1:0]     resp_in_base,
  output logic [AW-1:0]     resp_mask,
  output logic [AW-1:0]     resp_pa,
  output logic [1:0]        resp_perm,
  output logic [1:0]        resp_level,
  output logic [1:0]        resp_granule
);
  localparam int unsigned ISZ_W = 7;

  s2w_state_e    st_q;
  logic [AW-1:0] ipa_q, root_q, base_q, dsc_addr_q;
  logic          wr_q, af_off_q, sl_bad_q;
  logic [5:0]    tsz_q, osz_q;
  logic [1:0]    gran_q, lvl_q;

  s2w_fault_e    res_fault;
  logic [AW-1:0] res_fault_addr, res_in_base, res_mask, res_pa;
  logic [1:0]    res_perm, res_level;

  logic [1:0]    lvl_in;
  logic          sl_bad_in;
  logic [ISZ_W-1:0] in_size;
  logic          range_bad;

  logic [AW-1:0] lvl_mask, page_mask, idx_bytes, root_bytes;
  s2w_kind_e     kind;
  logic [AW-1:0] next_base, leaf_pa;
  s2w_fault_e    leaf_fault;
  logic [1:0]    leaf_perm;

  s2w_level_geom #(.AW(AW)) geom_i (
    .gran_code  (gran_q),
    .level      (lvl_q),
    .addr       (ipa_q),
    .lvl_mask   (lvl_mask),
    .page_mask  (page_mask),
    .idx_bytes  (idx_bytes),
    .root_bytes (root_bytes)
  );

  s2w_desc_eval #(.AW(AW)) eval_i (
    .desc       (mrsp_data),
    .level      (lvl_q),
    .lvl_mask   (lvl_mask),
    .page_mask  (page_mask),
    .req_write  (wr_q),
    .af_off     (af_off_q),
    .out_size   (osz_q),
    .kind       (kind),
    .next_base  (next_base),
    .leaf_pa    (leaf_pa),
    .leaf_fault (leaf_fault),
    .perm       (leaf_perm)
  );

  // start level from the configuration code
  always_comb begin
    sl_bad_in = 1'b0;
    if (cfg_granule == 2'd1 || cfg_granule == 2'd2) begin
      lvl_in = 2'd3 - cfg_start_code;
    end else begin
      lvl_in    = 2'd2 - cfg_start_code;
      sl_bad_in = (cfg_start_code == 2'd3);
    end
  end

  always_comb begin
    in_size = 7'd64 - {1'b0, tsz_q};
    if (32'(in_size) >= AW)
      range_bad = 1'b0;
    else
      range_bad = |(ipa_q >> in_size);
  end

  assign req_ready       = (st_q == ST_IDLE);
  assign mrd_valid       = (st_q == ST_ISSUE);
  assign mrd_addr        = base_q + idx_bytes;
  assign resp_valid      = (st_q == ST_RESP);
  assign resp_fault      = res_fault;
  assign resp_stage      = (res_fault != FLT_NONE) ? 2'd2 : 2'd0;
  assign resp_fault_addr = res_fault_addr;
  assign resp_in_base    = res_in_base;
  assign resp_mask       = res_mask;
  assign resp_pa         = res_pa;
  assign resp_perm       = res_perm;
  assign resp_level      = res_level;
  assign resp_granule    = gran_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      ipa_q          <= '0;
      root_q         <= '0;
      base_q         <= '0;
      dsc_addr_q     <= '0;
      wr_q           <= 1'b0;
      af_off_q       <= 1'b0;
      sl_bad_q       <= 1'b0;
      tsz_q          <= '0;
      osz_q          <= '0;
      gran_q         <= '0;
      lvl_q          <= '0;
      res_fault      <= FLT_NONE;
      res_fault_addr <= '0;
      res_in_base    <= '0;
      res_mask       <= '0;
      res_pa         <= '0;
      res_perm       <= '0;
      res_level      <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            ipa_q          <= req_addr;
            wr_q           <= req_write;
            tsz_q          <= cfg_tsz;
            gran_q         <= cfg_granule;
            lvl_q          <= lvl_in;
            sl_bad_q       <= sl_bad_in;
            root_q         <= cfg_root_base;
            osz_q          <= cfg_out_size;
            af_off_q       <= cfg_af_fault_off;
            res_fault      <= FLT_NONE;
            res_fault_addr <= '0;
            res_in_base    <= '0;
            res_mask       <= '0;
            res_pa         <= '0;
            res_perm       <= '0;
            res_level      <= '0;
            st_q           <= ST_START;
          end
        end
        ST_START: begin
          if (sl_bad_q || range_bad) begin
            res_fault      <= FLT_XLATE;
            res_fault_addr <= ipa_q;
            st_q           <= ST_RESP;
          end else begin
            base_q <= root_q + root_bytes;
            st_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mrd_ready) begin
            dsc_addr_q <= mrd_addr;
            st_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mrsp_valid) begin
            if (mrsp_err) begin
              res_fault      <= FLT_EXTABT;
              res_fault_addr <= dsc_addr_q;
              st_q           <= ST_RESP;
            end else if (kind == DK_INVALID) begin
              res_fault      <= FLT_XLATE;
              res_fault_addr <= ipa_q;
              st_q           <= ST_RESP;
            end else if (kind == DK_TABLE) begin
              base_q <= next_base;
              lvl_q  <= lvl_q + 2'd1;
              st_q   <= ST_ISSUE;
            end else if (leaf_fault != FLT_NONE) begin
              res_fault      <= leaf_fault;
              res_fault_addr <= ipa_q;
              st_q           <= ST_RESP;
            end else begin
              res_pa      <= leaf_pa;
              res_mask    <= lvl_mask;
              res_in_base <= ipa_q & ~lvl_mask;
              res_perm    <= leaf_perm;
              res_level   <= lvl_q;
              st_q        <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (resp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/s2w_chk.sv
module s2w_chk #(
  parameter int unsigned AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mrd_valid,
  input logic          mrd_ready,
  input logic [AW-1:0] mrd_addr,
  input logic          resp_valid,
  input logic          resp_ready,
  input logic [2:0]    resp_fault,
  input logic [1:0]    resp_stage,
  input logic [AW-1:0] resp_fault_addr,
  input logic [AW-1:0] resp_in_base,
  input logic [AW-1:0] resp_mask,
  input logic [AW-1:0] resp_pa,
  input logic [1:0]    resp_perm
);
  // R1
  resp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  // R1
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_pa) && $stable(resp_fault)
      && $stable(resp_fault_addr) && $stable(resp_mask));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

  // R5
  one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && mrd_ready |=> !mrd_valid);

  // R13
  fault_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault != 3'd0 |-> resp_perm == 2'd0 && resp_stage == 2'd2);

  // R9
  leaf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == 3'd0 |-> (resp_pa & resp_mask) == '0 && (resp_in_base & resp_mask) == '0);

  // R6
  abort_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == 3'd2 |-> resp_fault_addr[2:0] == 3'd0);
endmodule

bind s2_walker s2w_chk #(.AW(AW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .mrd_valid       (mrd_valid),
  .mrd_ready       (mrd_ready),
  .mrd_addr        (mrd_addr),
  .resp_valid      (resp_valid),
  .resp_ready      (resp_ready),
  .resp_fault      (resp_fault),
  .resp_stage      (resp_stage),
  .resp_fault_addr (resp_fault_addr),
  .resp_in_base    (resp_in_base),
  .resp_mask       (resp_mask),
  .resp_pa         (resp_pa),
  .resp_perm       (resp_perm)
);

// File: tb/s2_walker_tb_top.sv
`timescale 1ns/1ps
module s2_walker_tb_top;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [5:0]    cfg_tsz, cfg_out_size;
  logic [1:0]    cfg_granule, cfg_start_code;
  logic [AW-1:0] cfg_root_base;
  logic          cfg_af_fault_off;
  logic          mrd_valid, mrd_ready;
  logic [AW-1:0] mrd_addr;
  logic          mrsp_valid, mrsp_err;
  logic [63:0]   mrsp_data;
  logic          resp_valid, resp_ready;
  logic [2:0]    resp_fault;
  logic [1:0]    resp_stage, resp_perm, resp_level, resp_granule;
  logic [AW-1:0] resp_fault_addr, resp_in_base, resp_mask, resp_pa;

  s2_walker #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .cfg_tsz(cfg_tsz), .cfg_granule(cfg_granule), .cfg_start_code(cfg_start_code),
    .cfg_root_base(cfg_root_base), .cfg_out_size(cfg_out_size), .cfg_af_fault_off(cfg_af_fault_off),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .mrsp_err(mrsp_err),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
    .resp_stage(resp_stage), .resp_fault_addr(resp_fault_addr), .resp_in_base(resp_in_base),
    .resp_mask(resp_mask), .resp_pa(resp_pa), .resp_perm(resp_perm),
    .resp_level(resp_level), .resp_granule(resp_granule)
  );

  int checks = 0;
  int fails = 0;
  int reads = 0;
  logic [63:0]   mem [logic [47:0]];
  bit            berr [logic [47:0]];
  logic [47:0]   rd_log [$];

  int          r_lat, r_reads;
  logic [63:0] r_fault, r_stage, r_faddr, r_inb, r_mask, r_pa, r_perm, r_lvl;

  localparam logic [63:0] AF = 64'h400;

  function automatic logic [63:0] blk(input logic [63:0] pa, input bit af, input logic [1:0] ap);
    return pa | (af ? AF : 64'h0) | {56'h0, ap, 6'h0} | 64'h1;
  endfunction
  function automatic logic [63:0] pg(input logic [63:0] pa, input bit af, input logic [1:0] ap);
    return pa | (af ? AF : 64'h0) | {56'h0, ap, 6'h0} | 64'h3;
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // memory model: accepts at once, answers one cycle later
  initial begin
    mrsp_valid = 1'b0;
    mrsp_err   = 1'b0;
    mrsp_data  = '0;
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      mrsp_err   = 1'b0;
      if (rst_n && mrd_valid) begin
        logic [47:0] a;
        a = mrd_addr;
        rd_log.push_back(a);
        @(negedge clk);
        mrsp_valid = 1'b1;
        mrsp_data  = mem.exists(a) ? mem[a] : 64'h0;
        mrsp_err   = berr.exists(a);
        reads++;
      end
    end
  end

  task automatic setcfg(input logic [5:0] tsz, input logic [1:0] gran, input logic [1:0] sl,
                        input logic [5:0] osz, input bit afoff);
    cfg_tsz = tsz; cfg_granule = gran; cfg_start_code = sl;
    cfg_out_size = osz; cfg_af_fault_off = afoff; cfg_root_base = 48'h10000;
    mem.delete(); berr.delete(); rd_log.delete();
  endtask

  task automatic walk(input logic [47:0] ipa, input bit wr);
    int r0;
    r0 = reads;
    @(negedge clk);
    req_addr = ipa; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!resp_valid && r_lat < 100) begin
      @(negedge clk);
      r_lat++;
    end
    r_reads = reads - r0;
    r_fault = 64'(resp_fault); r_stage = 64'(resp_stage); r_faddr = 64'(resp_fault_addr);
    r_inb = 64'(resp_in_base); r_mask = 64'(resp_mask); r_pa = 64'(resp_pa);
    r_perm = 64'(resp_perm); r_lvl = 64'(resp_level);
    chk("R5", "latency", 64'(r_lat), 64'(2 + 2 * r_reads));
  endtask

  task automatic exp_ok(input string rq, input logic [63:0] pa, input logic [63:0] mask,
                        input logic [63:0] inb, input logic [1:0] perm, input logic [1:0] lvl, input int nrd);
    chk(rq, "fault", r_fault, 0);
    chk(rq, "pa", r_pa, pa);
    chk(rq, "mask", r_mask, mask);
    chk(rq, "in_base", r_inb, inb);
    chk(rq, "perm", r_perm, 64'(perm));
    chk(rq, "level", r_lvl, 64'(lvl));
    chk("R13", "stage on success", r_stage, 0);
    chk(rq, "reads", 64'(r_reads), 64'(nrd));
  endtask

  task automatic exp_flt(input string rq, input logic [2:0] code, input logic [63:0] faddr, input int nrd);
    chk(rq, "fault code", r_fault, 64'(code));
    chk(rq, "fault addr", r_faddr, faddr);
    chk(rq, "reads", 64'(r_reads), 64'(nrd));
    chk("R13", "fault perm", r_perm, 0);
    chk("R13", "fault stage", r_stage, 2);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready after reset", 64'(req_ready), 1);
    chk("R1", "resp_valid after reset", 64'(resp_valid), 0);
    chk("R5", "mrd_valid after reset", 64'(mrd_valid), 0);
  endtask

  task automatic t_page_walk;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h10488] = 64'h20003;
    mem[48'h20A28] = pg(64'h8_7654_3000, 1, 2'b11);
    walk(48'h1234_5678, 1'b0);
    exp_ok("R8", 64'h8_7654_3000, 64'hFFF, 64'h1234_5000, 2'b11, 2'd3, 2);
    chk("R5", "first descriptor addr", 64'(rd_log[0]), 64'h10488);
    chk("R8", "table next addr", 64'(rd_log[1]), 64'h20A28);
  endtask

  task automatic t_block_trim;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h10008] = blk(64'h4001_2000, 1, 2'b01);
    walk(48'h0034_5678, 1'b0);
    exp_ok("R9", 64'h4000_0000, 64'h1F_FFFF, 64'h20_0000, 2'b01, 2'd2, 1);
  endtask

  task automatic t_concat;
    setcfg(6'd32, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h13008] = blk(64'h7FE0_0000, 1, 2'b11);
    walk(48'hC020_0000, 1'b0);
    exp_ok("R4", 64'h7FE0_0000, 64'h1F_FFFF, 64'hC020_0000, 2'b11, 2'd2, 1);
    chk("R4", "root table 3 addr", 64'(rd_log[0]), 64'h13008);
  endtask

  task automatic t_range;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    walk(48'h4000_0000, 1'b0);
    exp_flt("R2", 3'd1, 64'h4000_0000, 0);
  endtask

  task automatic t_start_codes;
    setcfg(6'd34, 2'd0, 2'd3, 6'd48, 1'b0);
    walk(48'h1000, 1'b0);
    exp_flt("R3", 3'd1, 64'h1000, 0);
    setcfg(6'd25, 2'd0, 2'd1, 6'd48, 1'b0);
    mem[48'h10240] = blk(64'h8000_0000, 1, 2'b11);
    walk(48'h12_3456_7000, 1'b0);
    exp_ok("R3", 64'h8000_0000, 64'h3FFF_FFFF, 64'h12_0000_0000, 2'b11, 2'd1, 1);
    setcfg(6'd35, 2'd2, 2'd0, 6'd48, 1'b0);
    mem[48'h155E0] = pg(64'h5_0000_0000, 1, 2'b11);
    walk(48'h0ABC_1234, 1'b1);
    exp_ok("R3", 64'h5_0000_0000, 64'hFFFF, 64'h0ABC_0000, 2'b11, 2'd3, 1);
    chk("R3", "granule echo", 64'(resp_granule), 2);
  endtask

  task automatic t_abort;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h10488] = 64'h20003;
    berr[48'h20A28] = 1'b1;
    walk(48'h1234_5678, 1'b0);
    exp_flt("R6", 3'd2, 64'h20A28, 2);
  endtask

  task automatic t_invalid;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    walk(48'h1234_5678, 1'b0);
    exp_flt("R7", 3'd1, 64'h1234_5678, 1);
    mem[48'h10488] = 64'h20003;
    mem[48'h20A28] = blk(64'h8_7654_3000, 1, 2'b11);
    walk(48'h1234_5678, 1'b0);
    exp_flt("R7", 3'd1, 64'h1234_5678, 2);
  endtask

  task automatic t_access_flag;
    setcfg(6'd34, 2'd0, 2'd0, 6'd32, 1'b0);
    mem[48'h10008] = blk(64'h1_0000_0000, 0, 2'b01);
    walk(48'h0034_5678, 1'b1);
    exp_flt("R10", 3'd3, 64'h0034_5678, 1);
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b1);
    mem[48'h10008] = blk(64'h4000_0000, 0, 2'b01);
    walk(48'h0034_5678, 1'b1);
    exp_flt("R10", 3'd4, 64'h0034_5678, 1);
    mem[48'h10008] = blk(64'h4000_0000, 0, 2'b11);
    walk(48'h0034_5678, 1'b1);
    exp_ok("R10", 64'h4000_0000, 64'h1F_FFFF, 64'h20_0000, 2'b11, 2'd2, 1);
  endtask

  task automatic t_perm;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h10008] = blk(64'h4000_0000, 1, 2'b10);
    walk(48'h0034_5678, 1'b1);
    exp_ok("R11", 64'h4000_0000, 64'h1F_FFFF, 64'h20_0000, 2'b10, 2'd2, 1);
    walk(48'h0034_5678, 1'b0);
    exp_flt("R11", 3'd4, 64'h0034_5678, 1);
    mem[48'h10008] = blk(64'h1_0000_0000, 1, 2'b01);
    cfg_out_size = 6'd32;
    walk(48'h0034_5678, 1'b1);
    exp_flt("R11", 3'd4, 64'h0034_5678, 1);
  endtask

  task automatic t_size;
    setcfg(6'd34, 2'd0, 2'd0, 6'd32, 1'b0);
    mem[48'h10008] = blk(64'h1_0000_0000, 1, 2'b11);
    walk(48'h0034_5678, 1'b0);
    exp_flt("R12", 3'd5, 64'h0034_5678, 1);
    cfg_out_size = 6'd33;
    walk(48'h0034_5678, 1'b0);
    exp_ok("R12", 64'h1_0000_0000, 64'h1F_FFFF, 64'h20_0000, 2'b11, 2'd2, 1);
  endtask

  task automatic t_backpressure;
    int r0;
    logic [47:0] pa0;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    mem[48'h10008] = blk(64'h4000_0000, 1, 2'b11);
    @(negedge clk);
    resp_ready = 1'b0;
    req_addr = 48'h0034_5678; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 8 && !resp_valid; i++) @(negedge clk);
    chk("R1", "response raised", 64'(resp_valid), 1);
    pa0 = resp_pa;
    r0 = reads;
    req_addr = 48'h0000_1000; req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "held resp_valid", 64'(resp_valid), 1);
      chk("R1", "req_ready while held", 64'(req_ready), 0);
      chk("R1", "held pa", 64'(resp_pa), 64'(pa0));
    end
    req_valid = 1'b0;
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R1", "resp released", 64'(resp_valid), 0);
    chk("R1", "idle again", 64'(req_ready), 1);
    chk("R1", "no read from ignored request", 64'(reads - r0), 0);
    chk("R1", "result pa", 64'(pa0), 64'h4000_0000);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    mrd_ready = 1'b1; resp_ready = 1'b1;
    setcfg(6'd34, 2'd0, 2'd0, 6'd48, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_walk();
    t_block_trim();
    t_concat();
    t_range();
    t_start_codes();
    t_abort();
    t_invalid();
    t_access_flag();
    t_perm();
    t_size();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule